// File: doc/BRIEF.md
# Instruction Micro-TLB with Scratchpad Steering

This block sits on the instruction fetch path. Each fetch brings a virtual address, which is looked up in a small fully associative translation buffer. On a hit, the physical address is registered and appears one cycle after the fetch is accepted. In the same cycle the block also reports where the fetch must go: the scratchpad, the small instruction cache, or uncached main memory. The scratchpad is a naturally aligned physical window, selected by the high bits of a base value. A page's class decides between the cache and main memory when the address lies outside that window. The path carries instruction fetches only; no data port exists.

On a miss the fetch is stalled. The block raises a lookup request to the main TLB/MMU and holds it until the response arrives. A response flagged usable is written into the buffer, replacing entries in round-robin order, and the stalled fetch then hits. A response flagged unusable is not stored. Instead the stalled fetch is consumed and a page-fault pulse is produced for the software manager. A flush input empties the buffer so that software can change mappings after it moves code into or out of the scratchpad.

Top module: `itlb_spm_steer`

## Requirements
- R1: After reset, `out_valid_o`, `fault_o` and `mmu_req_o` are low and the buffer holds no entry, so the first fetch of any page misses.
- R2: A fetch that hits while no lookup is pending is accepted in its cycle (`fetch_ready_o` high). In the next cycle `out_valid_o` is high and `out_pa_o` is {stored physical page, virtual address bits [11:0]}.
- R3: A hit whose physical address has bits [PA_W-1:SPM_LOG2] equal to `spm_base_i` gives `out_dest_o` = 2'b01 (scratchpad), whatever the page class.
- R4: A hit outside the window on a page of class 2'b00 (cacheable), 2'b10 (pageable) or 2'b11 gives `out_dest_o` = 2'b00 (cache).
- R5: A hit outside the window on a page of class 2'b01 (non-cacheable) gives `out_dest_o` = 2'b10 (main memory).
- R6: A miss keeps `fetch_ready_o` low. From the next cycle `mmu_req_o` is high with `mmu_req_vpn_o` equal to the virtual page of the fetch, and both hold steady until `mmu_rsp_valid_i`.
- R7: A response with `mmu_rsp_ok_i` high stores the page and its class and ends the request. The held fetch then hits in the following cycle.
- R8: A response with `mmu_rsp_ok_i` low consumes the fetch (`fetch_ready_o` high in the response cycle). In the next cycle `fault_o` pulses with `fault_va_o` equal to the faulting virtual address and `out_valid_o` low. Nothing is stored, so a retry misses again.
- R9: Refills use entries 0, 1, 2 … in turn and wrap after the last. With 8 entries, the ninth refill after a flush replaces the first page stored and keeps the other eight.
- R10: `flush_i` empties the buffer and resets the refill order at the next edge. A refill arriving in the same cycle is dropped. A hit in the flush cycle still completes.
- R11: `mmu_rsp_valid_i` while no request is pending is ignored and stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empty the buffer |
| spm_base_i | input | PA_W-SPM_LOG2 | High bits of the scratchpad window base |
| fetch_valid_i | input | 1 | Fetch present; held until accepted |
| fetch_va_i | input | VA_W | Fetch virtual address |
| fetch_ready_o | output | 1 | Fetch accepted this cycle |
| out_valid_o | output | 1 | Translated fetch valid |
| out_pa_o | output | PA_W | Physical address |
| out_dest_o | output | 2 | 00 cache, 01 scratchpad, 10 main memory |
| fault_o | output | 1 | Page-fault pulse |
| fault_va_o | output | VA_W | Faulting virtual address |
| mmu_req_o | output | 1 | Lookup request to the main TLB/MMU |
| mmu_req_vpn_o | output | VA_W-PG_W | Virtual page requested |
| mmu_rsp_valid_i | input | 1 | Response present |
| mmu_rsp_ok_i | input | 1 | Page is mapped and usable |
| mmu_rsp_ppn_i | input | PPN_W | Physical page returned |
| mmu_rsp_class_i | input | 2 | Page class: 00 cacheable, 01 non-cacheable, 10 pageable |

## Verification
A corrupted entry, a wrong replacement pointer, or a flush that misses an entry shows up as a wrong hit or miss. That becomes visible on `fetch_ready_o` in the very cycle the affected page is next fetched, or as a wrong `out_pa_o` or `out_dest_o` one cycle later. A stuck request state shows at once on `mmu_req_o`. A response taken outside a request only shows later, when the stale page is fetched and hits instead of missing. The reference model therefore checks ready, request and output ports on every clock, so each divergence is caught within one cycle of reaching a port.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
  typedef enum logic [1:0] {
    PG_CACHED   = 2'b00,
    PG_UNCACHED = 2'b01,
    PG_SPM_OK   = 2'b10,
    PG_RSVD     = 2'b11
  } pg_class_e;

  typedef enum logic [1:0] {
    DST_CACHE = 2'b00,
    DST_SPM   = 2'b01,
    DST_MEM   = 2'b10
  } dest_e;

  typedef enum logic {
    ST_IDLE,
    ST_WAIT
  } miss_st_e;
endpackage

// File: rtl/utlb_cam.sv
module utlb_cam #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PPN_W   = 20,
  parameter int unsigned CLS_W   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [VPN_W-1:0] look_vpn_i,
  input  logic             fill_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic [CLS_W-1:0] fill_cls_i,
  output logic             hit_o,
  output logic [PPN_W-1:0] hit_ppn_o,
  output logic [CLS_W-1:0] hit_cls_o
);
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]            live_q;
  logic [ENTRIES-1:0]            match;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_sel;
  logic [ENTRIES-1:0][CLS_W-1:0] cls_sel;
  logic [IDX_W-1:0]              ptr_q;
  logic                          do_fill;

  // flush wins over a refill in the same cycle
  assign do_fill = fill_i & ~flush_i;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic [VPN_W-1:0] vpn_q;
    logic [PPN_W-1:0] ppn_q;
    logic [CLS_W-1:0] cls_q;

    always_ff @(posedge clk_i) begin
      if (do_fill && ptr_q == IDX_W'(g)) begin
        vpn_q <= fill_vpn_i;
        ppn_q <= fill_ppn_i;
        cls_q <= fill_cls_i;
      end
    end

    assign match[g]   = live_q[g] && (vpn_q == look_vpn_i);
    assign ppn_sel[g] = match[g] ? ppn_q : '0;
    assign cls_sel[g] = match[g] ? cls_q : '0;
  end

  always_comb begin
    hit_ppn_o = '0;
    hit_cls_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      hit_ppn_o = hit_ppn_o | ppn_sel[i];
      hit_cls_o = hit_cls_o | cls_sel[i];
    end
  end

  assign hit_o = |match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
      ptr_q  <= '0;
    end else if (flush_i) begin
      live_q <= '0;
      ptr_q  <= '0;
    end else if (do_fill) begin
      live_q[ptr_q] <= 1'b1;
      ptr_q         <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/utlb_steer.sv
module utlb_steer
  import itlb_pkg::*;
#(
  parameter int unsigned WIN_W = 18
) (
  input  logic [WIN_W-1:0] pa_hi_i,
  input  logic [WIN_W-1:0] base_i,
  input  logic [1:0]       cls_i,
  output dest_e            dest_o
);
  pg_class_e cls;
  assign cls = pg_class_e'(cls_i);

  always_comb begin
    if (pa_hi_i == base_i)           dest_o = DST_SPM;
    else if (cls == PG_UNCACHED)     dest_o = DST_MEM;
    else                             dest_o = DST_CACHE;
  end
endmodule

// File: rtl/utlb_miss_ctl.sv
module utlb_miss_ctl
  import itlb_pkg::*;
#(
  parameter int unsigned VA_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fetch_valid_i,
  input  logic [VA_W-1:0] fetch_va_i,
  input  logic            hit_i,
  input  logic            rsp_valid_i,
  input  logic            rsp_ok_i,
  output logic            busy_o,
  output logic [VA_W-1:0] wait_va_o,
  output logic            take_hit_o,
  output logic            fill_o,
  output logic            take_fault_o
);
  miss_st_e st_q;
  logic     idle, rsp_take;

  assign idle         = (st_q == ST_IDLE);
  assign rsp_take     = (st_q == ST_WAIT) && rsp_valid_i;
  assign take_hit_o   = idle && fetch_valid_i && hit_i;
  assign fill_o       = rsp_take && rsp_ok_i;
  assign take_fault_o = rsp_take && !rsp_ok_i;
  assign busy_o       = (st_q == ST_WAIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      wait_va_o <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (fetch_valid_i && !hit_i) begin
          st_q      <= ST_WAIT;
          wait_va_o <= fetch_va_i;
        end
        ST_WAIT: if (rsp_valid_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/itlb_spm_steer.sv
module itlb_spm_steer
  import itlb_pkg::*;
#(
  parameter int unsigned VA_W     = 32,
  parameter int unsigned PG_W     = 12,
  parameter int unsigned PPN_W    = 20,
  parameter int unsigned SPM_LOG2 = 14,
  parameter int unsigned ENTRIES  = 8,
  localparam int unsigned VPN_W   = VA_W - PG_W,
  localparam int unsigned PA_W    = PPN_W + PG_W,
  localparam int unsigned WIN_W   = PA_W - SPM_LOG2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [WIN_W-1:0] spm_base_i,
  input  logic             fetch_valid_i,
  input  logic [VA_W-1:0]  fetch_va_i,
  output logic             fetch_ready_o,
  output logic             out_valid_o,
  output logic [PA_W-1:0]  out_pa_o,
  output logic [1:0]       out_dest_o,
  output logic             fault_o,
  output logic [VA_W-1:0]  fault_va_o,
  output logic             mmu_req_o,
  output logic [VPN_W-1:0] mmu_req_vpn_o,
  input  logic             mmu_rsp_valid_i,
  input  logic             mmu_rsp_ok_i,
  input  logic [PPN_W-1:0] mmu_rsp_ppn_i,
  input  logic [1:0]       mmu_rsp_class_i
);
  logic             hit, take_hit, fill, take_fault;
  logic [PPN_W-1:0] hit_ppn;
  logic [1:0]       hit_cls;
  logic [VA_W-1:0]  wait_va;
  logic [PA_W-1:0]  pa;
  dest_e            dest;

  utlb_cam #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .CLS_W(2)
  ) i_cam (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .look_vpn_i (fetch_va_i[VA_W-1:PG_W]),
    .fill_i     (fill),
    .fill_vpn_i (wait_va[VA_W-1:PG_W]),
    .fill_ppn_i (mmu_rsp_ppn_i),
    .fill_cls_i (mmu_rsp_class_i),
    .hit_o      (hit),
    .hit_ppn_o  (hit_ppn),
    .hit_cls_o  (hit_cls)
  );

  utlb_miss_ctl #(.VA_W(VA_W)) i_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fetch_valid_i(fetch_valid_i),
    .fetch_va_i   (fetch_va_i),
    .hit_i        (hit),
    .rsp_valid_i  (mmu_rsp_valid_i),
    .rsp_ok_i     (mmu_rsp_ok_i),
    .busy_o       (mmu_req_o),
    .wait_va_o    (wait_va),
    .take_hit_o   (take_hit),
    .fill_o       (fill),
    .take_fault_o (take_fault)
  );

  assign pa = {hit_ppn, fetch_va_i[PG_W-1:0]};

  utlb_steer #(.WIN_W(WIN_W)) i_steer (
    .pa_hi_i (pa[PA_W-1:SPM_LOG2]),
    .base_i  (spm_base_i),
    .cls_i   (hit_cls),
    .dest_o  (dest)
  );

  assign fetch_ready_o = take_hit | take_fault;
  assign mmu_req_vpn_o = wait_va[VA_W-1:PG_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_pa_o    <= '0;
      out_dest_o  <= DST_CACHE;
      fault_o     <= 1'b0;
      fault_va_o  <= '0;
    end else begin
      out_valid_o <= take_hit;
      fault_o     <= take_fault;
      if (take_hit) begin
        out_pa_o   <= pa;
        out_dest_o <= dest;
      end
      if (take_fault) fault_va_o <= wait_va;
    end
  end
endmodule

// File: rtl/itlb_spm_steer_chk.sv
module itlb_spm_steer_chk #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PG_W  = 12,
  parameter int unsigned VPN_W = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic             fetch_valid_i,
  input logic [PG_W-1:0]  va_off_i,
  input logic             fetch_ready_o,
  input logic             out_valid_o,
  input logic [PG_W-1:0]  pa_off_i,
  input logic [1:0]       out_dest_o,
  input logic             fault_o,
  input logic [VPN_W-1:0] fault_vpn_i,
  input logic             mmu_req_o,
  input logic [VPN_W-1:0] mmu_req_vpn_o,
  input logic             mmu_rsp_valid_i,
  input logic             mmu_rsp_ok_i
);
  assert_hit_out_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_i && fetch_ready_o && !mmu_req_o |=> out_valid_o && pa_off_i == $past(va_off_i));

  assert_dest_code_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_dest_o != 2'b11);

  assert_stall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mmu_req_o && !mmu_rsp_valid_i |-> !fetch_ready_o);

  assert_req_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mmu_req_o && !mmu_rsp_valid_i |=> mmu_req_o && $stable(mmu_req_vpn_o));

  assert_fault_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mmu_req_o && mmu_rsp_valid_i && !mmu_rsp_ok_i |=>
      fault_o && !out_valid_o && fault_vpn_i == $past(mmu_req_vpn_o));

  assert_fault_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fault_o && out_valid_o));

  assert_flush_empty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(flush_i) && fetch_valid_i && !mmu_req_o |-> !fetch_ready_o);
endmodule

bind itlb_spm_steer itlb_spm_steer_chk #(
  .VA_W(VA_W), .PG_W(PG_W), .VPN_W(VPN_W)
) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .flush_i        (flush_i),
  .fetch_valid_i  (fetch_valid_i),
  .va_off_i       (fetch_va_i[PG_W-1:0]),
  .fetch_ready_o  (fetch_ready_o),
  .out_valid_o    (out_valid_o),
  .pa_off_i       (out_pa_o[PG_W-1:0]),
  .out_dest_o     (out_dest_o),
  .fault_o        (fault_o),
  .fault_vpn_i    (fault_va_o[VA_W-1:PG_W]),
  .mmu_req_o      (mmu_req_o),
  .mmu_req_vpn_o  (mmu_req_vpn_o),
  .mmu_rsp_valid_i(mmu_rsp_valid_i),
  .mmu_rsp_ok_i   (mmu_rsp_ok_i)
);

// File: tb/test_itlb_spm_steer.sv
`timescale 1ns/1ps
module test_itlb_spm_steer;
  localparam int ENT = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [17:0] spm_base = 18'h20010;  // window 0x8004_0000..0x8004_3FFF
  logic        fv = 1'b0;
  logic [31:0] fva = '0;
  logic        ready, ovalid, fault, req;
  logic [31:0] opa, fault_va;
  logic [1:0]  odest;
  logic [19:0] req_vpn;
  logic        rv = 1'b0, rok = 1'b0;
  logic [19:0] rppn = '0;
  logic [1:0]  rcls = '0;

  always #2.5 clk = ~clk;

  itlb_spm_steer i_itlb_spm_steer (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .spm_base_i(spm_base),
    .fetch_valid_i(fv), .fetch_va_i(fva), .fetch_ready_o(ready),
    .out_valid_o(ovalid), .out_pa_o(opa), .out_dest_o(odest),
    .fault_o(fault), .fault_va_o(fault_va),
    .mmu_req_o(req), .mmu_req_vpn_o(req_vpn),
    .mmu_rsp_valid_i(rv), .mmu_rsp_ok_i(rok),
    .mmu_rsp_ppn_i(rppn), .mmu_rsp_class_i(rcls)
  );

  int    n_chk = 0, n_bad = 0, cyc = 0;
  bit    done = 0;
  string cur_req = "R1";

  // page table seen by the bench's MMU stand-in
  int pt_ppn[int];
  int pt_cls[int];
  bit pt_ok[int];

  // reference model state
  bit          m_live[ENT];
  int          m_vpn[ENT], m_ppn[ENT], m_cls[ENT];
  int          m_ptr = 0;
  bit          m_wait = 0;
  logic [31:0] m_wva = '0;
  int          wcnt = 0, rsp_lat = 2;
  bit          last_ready = 0;
  bit          flush_now = 0, flush_on_rsp = 0, stray_now = 0;

  task automatic check(string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic map(int vpn, int ppn, int cls, bit ok);
    pt_ppn[vpn] = ppn; pt_cls[vpn] = cls; pt_ok[vpn] = ok;
  endtask

  task automatic step();
    bit          hit, take_f;
    int          hi, vpn;
    logic [31:0] e_pa;
    logic [1:0]  e_dest;
    bit          e_ready;
    rv = 0; rok = 0; rppn = '0; rcls = '0;
    if (m_wait && wcnt >= rsp_lat) begin
      vpn = int'(m_wva[31:12]);
      rv  = 1;
      if (pt_ok.exists(vpn)) begin
        rok = pt_ok[vpn]; rppn = pt_ppn[vpn][19:0]; rcls = pt_cls[vpn][1:0];
      end
    end
    if (stray_now) begin rv = 1; rok = 1; rppn = 20'h12345; rcls = 2'b00; end
    flush = flush_now || (flush_on_rsp && rv && m_wait);
    if (flush_on_rsp && rv && m_wait) flush_on_rsp = 0;
    #1;
    hit = 0; hi = 0;
    if (!m_wait && fv)
      for (int i = 0; i < ENT; i++)
        if (m_live[i] && m_vpn[i] == int'(fva[31:12])) begin hit = 1; hi = i; end
    take_f  = m_wait && rv && !rok;
    e_ready = hit || take_f;
    check("fetch_ready", 64'(ready), 64'(e_ready));
    check("mmu_req", 64'(req), 64'(m_wait));
    if (m_wait) check("mmu_req_vpn", 64'(req_vpn), 64'(m_wva[31:12]));
    e_pa = {m_ppn[hi][19:0], fva[11:0]};
    if ((e_pa >> 14) == 32'(spm_base)) e_dest = 2'b01;
    else if (m_cls[hi] == 1)           e_dest = 2'b10;
    else                               e_dest = 2'b00;
    @(posedge clk); @(negedge clk);
    check("out_valid", 64'(ovalid), 64'(hit));
    if (hit) begin
      check("out_pa", 64'(opa), 64'(e_pa));
      check("out_dest", 64'(odest), 64'(e_dest));
    end
    check("fault", 64'(fault), 64'(take_f));
    if (take_f) check("fault_va", 64'(fault_va), 64'(m_wva));
    // model state update
    if (flush) begin
      for (int i = 0; i < ENT; i++) m_live[i] = 0;
      m_ptr = 0;
    end else if (m_wait && rv && rok) begin
      m_live[m_ptr] = 1; m_vpn[m_ptr] = int'(m_wva[31:12]);
      m_ppn[m_ptr] = int'(rppn); m_cls[m_ptr] = int'(rcls);
      m_ptr = (m_ptr + 1) % ENT;
    end
    if (m_wait) begin
      if (rv) m_wait = 0; else wcnt++;
    end else if (fv && !hit) begin
      m_wait = 1; m_wva = fva; wcnt = 0;
    end
    last_ready = e_ready;
    flush_now = 0; stray_now = 0;
  endtask

  task automatic idle(int n);
    fv = 0;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_fetch(logic [31:0] va);
    int n = 0;
    fv = 1; fva = va;
    do begin step(); n++; end while (!last_ready && n < 60);
    fv = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1; n_bad++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ENT; i++) begin m_live[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0; m_cls[i] = 0; end
    map(32'h00401, 32'h80010, 0, 1);  // cacheable, outside window
    map(32'h00402, 32'h80041, 2, 1);  // pageable, inside window
    map(32'h00403, 32'h90000, 1, 1);  // non-cacheable, outside
    map(32'h00404, 32'h80043, 1, 1);  // non-cacheable, top page of window
    map(32'h00405, 32'h80044, 2, 1);  // pageable, just above window
    map(32'h00406, 32'h8003F, 3, 1);  // class 3, just below window
    map(32'h00500, 32'h0, 0, 0);      // unusable page
    for (int i = 0; i < 9; i++) map(32'h100 + i, 32'h70000 + i, 0, 1);

    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    cur_req = "R1";    idle(3);
    do_fetch(32'h0040_1234);  // R1: first fetch must miss
    cur_req = "R6 R7"; do_fetch(32'h0040_2010);
    cur_req = "R2";    do_fetch(32'h0040_1ABC); do_fetch(32'h0040_1000); do_fetch(32'h0040_1FFF);
    cur_req = "R3";    do_fetch(32'h0040_2010); do_fetch(32'h0040_4FFC); do_fetch(32'h0040_4FFC);
    cur_req = "R4";    do_fetch(32'h0040_5000); do_fetch(32'h0040_5000);
    rsp_lat = 0;       do_fetch(32'h0040_6444); do_fetch(32'h0040_6444);
    rsp_lat = 3;
    cur_req = "R5";    do_fetch(32'h0040_3008); do_fetch(32'h0040_3FF8);
    cur_req = "R8";    do_fetch(32'h0050_0040);
    cur_req = "R11";   stray_now = 1; idle(1); idle(1);
    cur_req = "R8";    do_fetch(32'h0050_0040);
    cur_req = "R10";   flush_now = 1; do_fetch(32'h0040_1234);  // hit during flush
    do_fetch(32'h0040_1234);                                     // now misses
    flush_on_rsp = 1;  do_fetch(32'h0040_2000);                  // first refill dropped
    do_fetch(32'h0040_2004);
    cur_req = "R9";    flush_now = 1; idle(1);
    for (int i = 0; i < 9; i++) do_fetch(32'((32'h100 + i) << 12));
    for (int i = 1; i < 9; i++) do_fetch(32'(((32'h100 + i) << 12) | 32'h80));
    do_fetch(32'h0010_0000);  // evicted, misses
    idle(2);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule